// File: doc/BRIEF.md
# Ring-Windowed Register File

This block is a general-purpose register file whose storage is arranged as a ring of overlapping register windows. At any moment software sees 32 architectural registers: eight shared globals plus one window of 24 registers, made up of eight outs, eight locals and eight ins. A current-window pointer chooses the visible window. A save strobe, issued on a procedure call, moves the pointer one step forward. A restore strobe, issued on a return, moves it one step back. The pointer wraps modulo the window count.

Adjacent windows share eight physical registers. The outs of the caller become the ins of the callee, so arguments go in and results come back with no copying. The return address can sit in one of these registers. Each window's locals are private to that window. The physical storage holds 8 + 16 × NWIN registers, and the ins of window w are the same registers as the outs of window (w − 1) mod NWIN.

A window-invalid mask, driven by outside trap software, marks windows that still hold live data for some older frame. If a save or restore would move the pointer into a marked window, the pointer stays where it is and the block raises a one-cycle overflow or underflow trap request. Spilling and filling memory is left to the handler.

The window controller is a three-state machine:
- `CTL_RUN`: normal operation.
- `CTL_OVF`: one cycle, drives the overflow request.
- `CTL_UNF`: one cycle, drives the underflow request.

It has these transitions:
- RUN→OVF: a save whose target window is marked.
- RUN→UNF: a restore whose target window is marked.
- RUN→RUN: an accepted move, no strobe, or both strobes at once.
- OVF→RUN and UNF→RUN: unconditional after one cycle.

Top module: `ringwin_regfile`

## Requirements
- R1: After reset the window pointer is 0, both trap requests are low and every architectural register reads 0 in every window.
- R2: Register index 0 always reads 0 on both read ports, and a write to index 0 has no effect.
- R3: Indices 0–7 address the same eight global registers whatever the window pointer is.
- R4: Indices 16–23 (locals) address registers private to the current window; writing a local in one window leaves the locals of every other window unchanged.
- R5: Indices 8–15 (outs) of window w and indices 24–31 (ins) of window (w+1) mod NWIN are the same physical registers, so a value written as an out is read as the matching in after a save, and an in written by the callee is read as the matching out after the restore.
- R6: An accepted save sets the pointer to (cwp+1) mod NWIN and an accepted restore sets it to (cwp−1) mod NWIN, both effective on the next clock edge, with NWIN−1 wrapping to 0 and 0 wrapping to NWIN−1.
- R7: A save in the run state whose target window has its mask bit set leaves the pointer unchanged and drives `ovf_trap` high for exactly the one cycle after the edge.
- R8: A restore in the run state whose target window has its mask bit set leaves the pointer unchanged and drives `unf_trap` high for exactly the one cycle after the edge.
- R9: Save and restore strobes are ignored while a trap request is high, and when both strobes are high together. The two trap requests are never high together.
- R10: The read ports are combinational and independent. A write updates the register addressed through the pointer in effect at that edge, and the new value is visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A architectural index |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 5 | Read port B architectural index |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write architectural index |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Call strobe: advance window |
| restore_req | input | 1 | Return strobe: step window back |
| wim | input | NWIN | Window-invalid mask, one bit per window |
| cwp | output | $clog2(NWIN) | Current window pointer |
| ovf_trap | output | 1 | Overflow trap request |
| unf_trap | output | 1 | Underflow trap request |

## Verification
The case that is hardest to reach from the ports is aliasing across the wrap point. Showing that window NWIN−1's outs really are window 0's ins needs data planted through several windows and then read back after the pointer has gone all the way round the ring. The bench uses a four-window configuration. It writes distinct values to every writable index in every window, keeps a model of the physical storage built from the mapping in the requirements, then makes two full laps forward and two backward. Every index is compared on both ports in every window it passes. Trap entry is reached by setting single mask bits next to a known pointer. Strobes are then issued inside the one-cycle trap window.

// File: rtl/ringwin_pkg.sv
package ringwin_pkg;
    typedef enum logic [1:0] {
        CTL_RUN = 2'd0,
        CTL_OVF = 2'd1,
        CTL_UNF = 2'd2
    } ctl_state_e;

    localparam int ARCH_IDX_W = 5;
    localparam int GROUP_SZ   = 8;
endpackage

// File: rtl/ringwin_map.sv
module ringwin_map #(
    parameter int NWIN = 8
) (
    input  logic [$clog2(NWIN)-1:0]         cwp,
    input  logic [4:0]                      arch_idx,
    output logic [$clog2(8+16*NWIN)-1:0]    phys_idx
);
    localparam int CW    = $clog2(NWIN);
    localparam int NPHYS = 8 + 16 * NWIN;
    localparam int PW    = $clog2(NPHYS);

    logic [CW-1:0] prev_w;
    logic [PW-1:0] base_cur;
    logic [PW-1:0] base_prev;
    logic [PW-1:0] offs;

    always_comb begin
        prev_w    = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
        base_cur  = PW'(8) + (PW'(cwp) << 4);
        base_prev = PW'(8) + (PW'(prev_w) << 4);
        offs      = PW'(arch_idx[2:0]);
        unique case (arch_idx[4:3])
            2'd0:    phys_idx = offs;
            2'd1:    phys_idx = base_cur + offs;
            2'd2:    phys_idx = base_cur + PW'(8) + offs;
            default: phys_idx = base_prev + offs;
        endcase
    end
endmodule

// File: rtl/ringwin_ctrl.sv
module ringwin_ctrl
    import ringwin_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    save_req,
    input  logic                    restore_req,
    input  logic [NWIN-1:0]         wim,
    output logic [$clog2(NWIN)-1:0] cwp,
    output logic                    ovf_trap,
    output logic                    unf_trap
);
    localparam int CW = $clog2(NWIN);

    ctl_state_e    state_q, state_d;
    logic [CW-1:0] cwp_q, cwp_d;
    logic [CW-1:0] up_w, dn_w;
    logic          do_save, do_rest;

    always_comb begin
        up_w    = (cwp_q == CW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
        dn_w    = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - 1'b1;
        do_save = save_req && !restore_req;
        do_rest = restore_req && !save_req;
        state_d = state_q;
        cwp_d   = cwp_q;
        unique case (state_q)
            CTL_RUN: begin
                if (do_save) begin
                    if (wim[up_w]) state_d = CTL_OVF;
                    else           cwp_d   = up_w;
                end else if (do_rest) begin
                    if (wim[dn_w]) state_d = CTL_UNF;
                    else           cwp_d   = dn_w;
                end
            end
            CTL_OVF: state_d = CTL_RUN;
            CTL_UNF: state_d = CTL_RUN;
            default: state_d = CTL_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_RUN;
            cwp_q   <= '0;
        end else begin
            state_q <= state_d;
            cwp_q   <= cwp_d;
        end
    end

    always_comb begin
        cwp      = cwp_q;
        ovf_trap = (state_q == CTL_OVF);
        unf_trap = (state_q == CTL_UNF);
    end
endmodule

// File: rtl/ringwin_store.sv
module ringwin_store #(
    parameter int NPHYS = 136,
    parameter int XLEN  = 32,
    parameter int NRD   = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [$clog2(NPHYS)-1:0]              wr_phys,
    input  logic [XLEN-1:0]                       wr_data,
    input  logic [NRD-1:0][$clog2(NPHYS)-1:0]     rd_phys,
    output logic [NRD-1:0][XLEN-1:0]              rd_data
);
    localparam int PW = $clog2(NPHYS);

    logic [XLEN-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (wr_en && wr_phys != '0) begin
            mem[wr_phys] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_data[p] = (rd_phys[p] == PW'(0)) ? '0 : mem[rd_phys[p]];
        end
    end
endmodule

// File: rtl/ringwin_regfile.sv
module ringwin_regfile #(
    parameter int NWIN = 8,
    parameter int XLEN = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4:0]              rd_a_idx,
    output logic [XLEN-1:0]         rd_a_data,
    input  logic [4:0]              rd_b_idx,
    output logic [XLEN-1:0]         rd_b_data,
    input  logic                    wr_en,
    input  logic [4:0]              wr_idx,
    input  logic [XLEN-1:0]         wr_data,
    input  logic                    save_req,
    input  logic                    restore_req,
    input  logic [NWIN-1:0]         wim,
    output logic [$clog2(NWIN)-1:0] cwp,
    output logic                    ovf_trap,
    output logic                    unf_trap
);
    localparam int NPHYS = 8 + 16 * NWIN;
    localparam int PW    = $clog2(NPHYS);
    localparam int NPORT = 3;

    logic [NPORT-1:0][4:0]    idx_v;
    logic [NPORT-1:0][PW-1:0] phys_v;
    logic [1:0][PW-1:0]       rd_phys;
    logic [1:0][XLEN-1:0]     rd_data;

    assign idx_v[0] = rd_a_idx;
    assign idx_v[1] = rd_b_idx;
    assign idx_v[2] = wr_idx;

    ringwin_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .wim         (wim),
        .cwp         (cwp),
        .ovf_trap    (ovf_trap),
        .unf_trap    (unf_trap)
    );

    for (genvar k = 0; k < NPORT; k++) begin : g_map
        ringwin_map #(.NWIN(NWIN)) u_map (
            .cwp      (cwp),
            .arch_idx (idx_v[k]),
            .phys_idx (phys_v[k])
        );
    end

    assign rd_phys[0] = phys_v[0];
    assign rd_phys[1] = phys_v[1];

    ringwin_store #(.NPHYS(NPHYS), .XLEN(XLEN), .NRD(2)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_phys (phys_v[2]),
        .wr_data (wr_data),
        .rd_phys (rd_phys),
        .rd_data (rd_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
endmodule

// File: rtl/ringwin_regfile_chk.sv
module ringwin_regfile_chk #(
    parameter int NWIN = 8,
    parameter int XLEN = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [4:0]              rd_a_idx,
    input logic [XLEN-1:0]         rd_a_data,
    input logic [4:0]              rd_b_idx,
    input logic [XLEN-1:0]         rd_b_data,
    input logic                    wr_en,
    input logic [4:0]              wr_idx,
    input logic [XLEN-1:0]         wr_data,
    input logic                    save_req,
    input logic                    restore_req,
    input logic [NWIN-1:0]         wim,
    input logic [$clog2(NWIN)-1:0] cwp,
    input logic                    ovf_trap,
    input logic                    unf_trap
);
    localparam int CW = $clog2(NWIN);

    logic [CW-1:0] nxt_w, prv_w;
    logic          idle, sv_only, rs_only;

    assign nxt_w   = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;
    assign prv_w   = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
    assign idle    = !ovf_trap && !unf_trap;
    assign sv_only = save_req && !restore_req;
    assign rs_only = restore_req && !save_req;

    assert_g0_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));
    assert_g0_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == 5'd0) |-> (rd_b_data == '0));
    assert_save_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && sv_only && !wim[nxt_w]) |=> (cwp == $past(nxt_w)));
    assert_restore_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rs_only && !wim[prv_w]) |=> (cwp == $past(prv_w)));
    assert_ovf_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && sv_only && wim[nxt_w]) |=> (ovf_trap && $stable(cwp)));
    assert_ovf_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |=> !ovf_trap);
    assert_unf_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rs_only && wim[prv_w]) |=> (unf_trap && $stable(cwp)));
    assert_unf_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |=> !unf_trap);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle || (save_req && restore_req)) |=> $stable(cwp));
    assert_trap_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_trap && unf_trap));
endmodule

bind ringwin_regfile ringwin_regfile_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (.*);

// File: tb/ringwin_regfile_test.sv
`timescale 1ns/1ps
module ringwin_regfile_test;
    localparam int NW    = 4;
    localparam int XL    = 32;
    localparam int NPHYS = 8 + 16 * NW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [XL-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic [NW-1:0] wim = '0;
    logic [1:0]    cwp;
    logic          ovf_trap, unf_trap;

    int checks = 0;
    int errors = 0;
    int mw = 0;
    logic [XL-1:0] mdl [NPHYS];

    always #5 clk = ~clk;

    ringwin_regfile #(.NWIN(NW), .XLEN(XL)) uut (.*);

    function automatic int phys_of(int w, int r);
        if (r < 8)  return r;
        if (r < 16) return 8 + 16 * w + (r - 8);
        if (r < 24) return 16 + 16 * w + (r - 16);
        return 8 + 16 * ((w + NW - 1) % NW) + (r - 24);
    endfunction

    task automatic chk(string req, logic [XL-1:0] act, logic [XL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(int r, logic [XL-1:0] d);
        wr_en = 1'b1; wr_idx = 5'(r); wr_data = d;
        step();
        wr_en = 1'b0;
        if (r != 0) mdl[phys_of(mw, r)] = d;
    endtask

    task automatic do_save();
        save_req = 1'b1; step(); save_req = 1'b0;
        mw = (mw + 1) % NW;
        chk("R6 save step", XL'(cwp), XL'(mw));
    endtask

    task automatic do_restore();
        restore_req = 1'b1; step(); restore_req = 1'b0;
        mw = (mw + NW - 1) % NW;
        chk("R6 restore step", XL'(cwp), XL'(mw));
    endtask

    task automatic read_all(string req);
        for (int r = 0; r < 32; r++) begin
            rd_a_idx = 5'(r);
            rd_b_idx = 5'(31 - r);
            #1;
            chk(req, rd_a_data, (r == 0) ? '0 : mdl[phys_of(mw, r)]);
            chk(req, rd_b_data, (r == 31) ? '0 : mdl[phys_of(mw, 31 - r)]);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NPHYS; i++) mdl[i] = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 cwp", XL'(cwp), 0);
        chk("R1 ovf", XL'(ovf_trap), 0);
        chk("R1 unf", XL'(unf_trap), 0);
        for (int w = 0; w < NW; w++) begin
            read_all("R1 zero after reset");
            do_save();
        end
        // Fill every window; ins overwrite predecessor outs (R5 model)
        for (int w = 0; w < NW; w++) begin
            for (int r = 1; r < 32; r++)
                wr(r, 32'hA500_0000 | (w << 8) | r);
            read_all("R10 write then read");
            do_save();
        end
        // Two laps forward then two back: R3 globals, R4 locals, R5 overlap, R6 wrap
        for (int k = 0; k < 2 * NW; k++) begin
            read_all("R3/R4/R5 forward lap");
            do_save();
        end
        for (int k = 0; k < 2 * NW; k++) begin
            do_restore();
            read_all("R3/R4/R5 backward lap");
        end
        // R4: local written in one window only
        wr(17, 32'h1111_2222);
        do_save();
        rd_a_idx = 5'd17; #1;
        chk("R4 local private", rd_a_data, mdl[phys_of(mw, 17)]);
        do_restore();
        rd_a_idx = 5'd17; #1;
        chk("R4 local kept", rd_a_data, 32'h1111_2222);
        // R5 explicit: argument out, result back
        wr(9, 32'hCAFE_0009);
        do_save();
        rd_a_idx = 5'd25; #1;
        chk("R5 out seen as in", rd_a_data, 32'hCAFE_0009);
        wr(24, 32'hBEEF_0024);
        do_restore();
        rd_b_idx = 5'd8; #1;
        chk("R5 result seen as out", rd_b_data, 32'hBEEF_0024);
        // R2: index 0
        wr(0, 32'hFFFF_FFFF);
        rd_a_idx = 5'd0; rd_b_idx = 5'd0; #1;
        chk("R2 g0 port a", rd_a_data, '0);
        chk("R2 g0 port b", rd_b_data, '0);
        // R10 same-cycle write with save uses old window
        wr_en = 1'b1; wr_idx = 5'd18; wr_data = 32'h5A5A_0018; save_req = 1'b1;
        step();
        wr_en = 1'b0; save_req = 1'b0;
        mdl[phys_of(mw, 18)] = 32'h5A5A_0018;
        mw = (mw + 1) % NW;
        do_restore();
        rd_a_idx = 5'd18; #1;
        chk("R10 write uses old window", rd_a_data, 32'h5A5A_0018);
        // R7 overflow trap
        while (mw != 1) do_save();
        wim = 4'b0100;
        save_req = 1'b1; step(); save_req = 1'b0;
        chk("R7 ovf high", XL'(ovf_trap), 1);
        chk("R7 cwp held", XL'(cwp), 1);
        // R9 restore during trap cycle ignored
        restore_req = 1'b1; step(); restore_req = 1'b0;
        chk("R7 ovf one cycle", XL'(ovf_trap), 0);
        chk("R9 strobe in trap ignored", XL'(cwp), 1);
        chk("R9 no unf", XL'(unf_trap), 0);
        // R8 underflow trap
        wim = 4'b0001;
        restore_req = 1'b1; step(); restore_req = 1'b0;
        chk("R8 unf high", XL'(unf_trap), 1);
        chk("R8 cwp held", XL'(cwp), 1);
        chk("R9 trap exclusive", XL'(ovf_trap), 0);
        save_req = 1'b1; step(); save_req = 1'b0;
        chk("R8 unf one cycle", XL'(unf_trap), 0);
        chk("R9 save in trap ignored", XL'(cwp), 1);
        // R9 both strobes
        wim = '0;
        save_req = 1'b1; restore_req = 1'b1; step();
        save_req = 1'b0; restore_req = 1'b0;
        chk("R9 both strobes", XL'(cwp), 1);
        chk("R9 no trap on both", XL'(ovf_trap | unf_trap), 0);
        // wrap trap: cwp NW-1 save into marked window 0
        while (mw != NW - 1) do_save();
        wim = 4'b0001;
        save_req = 1'b1; step(); save_req = 1'b0;
        chk("R7 ovf at wrap", XL'(ovf_trap), 1);
        chk("R7 cwp held at wrap", XL'(cwp), NW - 1);
        step();
        wim = '0;
        read_all("R10 data intact after traps");
        finish_run();
    end
endmodule